// File: doc/BRIEF.md
# Signed-Magnitude Adder/Subtractor

This unit adds or subtracts two numbers held as a magnitude plus a separate sign bit. An operation is offered on a valid/ready input channel, together with a select that chooses addition or subtraction. The unit captures both operands into internal registers. The first operand's registers act as the accumulator, and the result is written back into them.

The XOR of the two signs and the operation select decide between two paths. One path adds the magnitudes. The other subtracts them by adding the first magnitude to the second one's inverted bits with a carry-in of one. A complementer under a mode bit feeds one shared ripple adder, and an end-carry flip-flop keeps the adder's carry out. On the subtract path that carry shows which magnitude was larger. When it is clear, one extra cycle two's-complements the accumulator and inverts its sign. A zero difference always leaves with a plus sign.

The result is presented on a valid/ready output channel. The result stays on the output until the consumer takes it. While the unit is busy or holding a result, it does not accept a new operation. Back-pressure on the output therefore stalls the input as well.

Top module: `sm_addsub`

## Requirements
- R1: The magnitudes are added when `in_sub`=0 with equal signs, or `in_sub`=1 with differing signs. The result magnitude is the sum modulo 2^MAG_W, the sign is the first operand's sign, and both `out_carry` and `out_ovf` equal the carry out of the sum. This holds even when the sum wraps to zero.
- R2: On the subtract path (every case not covered by R1), `out_ovf` is 0.
- R3: On the subtract path with first magnitude ≥ second, the result magnitude is the first minus the second, the sign is the first operand's sign, and `out_carry` is 1.
- R4: On the subtract path with first magnitude < second, the result magnitude is the second minus the first, the sign is the inverse of the first operand's sign, and `out_carry` is 0.
- R5: A subtract-path result whose magnitude is zero always carries sign 0 (plus).
- R6: Count falling edges after the rising edge that accepts an operation. `out_valid` is first high on the second falling edge for R1 and R3 cases, and on the third falling edge for R4 cases.
- R7: `in_ready` is 1 only while idle. An `in_valid` offered while `in_ready` is 0 is not captured and does not change the result in progress.
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and all result outputs hold their values. After the edge where both are 1, the unit returns to idle with `in_ready`=1.
- R9: While `rst_n`=0 the unit shows `in_ready`=1, `out_valid`=0, and all result outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit idle, operation will be taken on this edge |
| in_sub | input | 1 | 0 = add, 1 = subtract second operand from first |
| in_a_sign | input | 1 | First operand sign (1 = minus) |
| in_a_mag | input | MAG_W | First operand magnitude |
| in_b_sign | input | 1 | Second operand sign (1 = minus) |
| in_b_mag | input | MAG_W | Second operand magnitude |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_sign | output | 1 | Result sign |
| out_mag | output | MAG_W | Result magnitude |
| out_ovf | output | 1 | Magnitude overflow on the add path |
| out_carry | output | 1 | End carry of the last adder pass |

## Verification
Two pairs of events can fall into the same cycle. The first is the output stall and a new request. Results are held back for several cycles while the bench keeps a fresh operation ready. The bench must then see the held result stay frozen and the request wait for `in_ready`. In the second pair, the end carry and the forcing of a zero sign are both decided in the same calculation cycle. Equal magnitudes with a minus first operand, including both operands at zero, must leave with carry 1 and sign plus. Noise offered on the input during the calculation cycle is judged by comparing the result against the operands that were actually accepted.

// File: rtl/smas_pkg.sv
package smas_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_FIX  = 2'd2,
    ST_HOLD = 2'd3
  } smas_state_e;

endpackage

// File: rtl/smas_cmpl.sv
module smas_cmpl #(
  parameter int W = 8
) (
  input  logic         mode,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = din[i] ^ mode;
  end

endmodule

// File: rtl/smas_padd.sv
module smas_padd #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] c;

  assign c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic p;
    assign p        = x[i] ^ y[i];
    assign sum[i]   = p ^ c[i];
    assign c[i+1]   = (x[i] & y[i]) | (c[i] & p);
  end

  assign cout = c[W];

endmodule

// File: rtl/smas_ctrl.sv
module smas_ctrl
  import smas_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        out_ready,
  input  logic        add_path,
  input  logic        end_carry,
  output smas_state_e st,
  output logic        in_ready,
  output logic        out_valid,
  output logic        load_en,
  output logic        calc_en,
  output logic        fix_en
);

  smas_state_e st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (in_valid) st_nx = ST_CALC;
      ST_CALC: st_nx = (add_path || end_carry) ? ST_HOLD : ST_FIX;
      ST_FIX:  st_nx = ST_HOLD;
      ST_HOLD: if (out_ready) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assign in_ready  = (st == ST_IDLE);
  assign out_valid = (st == ST_HOLD);
  assign load_en   = (st == ST_IDLE) && in_valid;
  assign calc_en   = (st == ST_CALC);
  assign fix_en    = (st == ST_FIX);

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  // R8
  out_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready);

  // R6
  calc_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CALC) |=> (st == ST_HOLD || st == ST_FIX));

endmodule

// File: rtl/sm_addsub.sv
module sm_addsub
  import smas_pkg::*;
#(
  parameter int MAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sub,
  input  logic             in_a_sign,
  input  logic [MAG_W-1:0] in_a_mag,
  input  logic             in_b_sign,
  input  logic [MAG_W-1:0] in_b_mag,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_sign,
  output logic [MAG_W-1:0] out_mag,
  output logic             out_ovf,
  output logic             out_carry
);

  localparam logic [MAG_W-1:0] MAG_ZERO = '0;

  logic [MAG_W-1:0] a_q, b_q;
  logic             as_q, bs_q, sub_q;
  logic             e_q, avf_q, path_add_q;

  smas_state_e      st;
  logic             load_en, calc_en, fix_en;

  logic             add_path;
  logic             mode;
  logic [MAG_W-1:0] add_x, add_y, y_c, sum;
  logic             cout, sum_zero;

  // add magnitudes on equal signs for add, differing signs for subtract
  assign add_path = ~(as_q ^ bs_q ^ sub_q);

  always_comb begin
    if (st == ST_FIX) begin
      add_x = MAG_ZERO;
      add_y = a_q;
      mode  = 1'b1;
    end else begin
      add_x = a_q;
      add_y = b_q;
      mode  = ~add_path;
    end
  end

  smas_cmpl #(.W(MAG_W)) u_cmpl (
    .mode (mode),
    .din  (add_y),
    .dout (y_c)
  );

  smas_padd #(.W(MAG_W)) u_padd (
    .x    (add_x),
    .y    (y_c),
    .cin  (mode),
    .sum  (sum),
    .cout (cout)
  );

  assign sum_zero = (sum == MAG_ZERO);

  smas_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .add_path  (add_path),
    .end_carry (cout),
    .st        (st),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .load_en   (load_en),
    .calc_en   (calc_en),
    .fix_en    (fix_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q        <= '0;
      b_q        <= '0;
      as_q       <= 1'b0;
      bs_q       <= 1'b0;
      sub_q      <= 1'b0;
      e_q        <= 1'b0;
      avf_q      <= 1'b0;
      path_add_q <= 1'b0;
    end else if (load_en) begin
      a_q        <= in_a_mag;
      b_q        <= in_b_mag;
      as_q       <= in_a_sign;
      bs_q       <= in_b_sign;
      sub_q      <= in_sub;
      e_q        <= 1'b0;
      avf_q      <= 1'b0;
      path_add_q <= 1'b0;
    end else if (calc_en) begin
      a_q        <= sum;
      e_q        <= cout;
      path_add_q <= add_path;
      if (add_path) begin
        avf_q <= cout;
      end else begin
        avf_q <= 1'b0;
        if (cout && sum_zero) as_q <= 1'b0;
      end
    end else if (fix_en) begin
      a_q  <= sum;
      as_q <= sum_zero ? 1'b0 : ~as_q;
    end
  end

  assign out_mag   = a_q;
  assign out_sign  = as_q;
  assign out_ovf   = avf_q;
  assign out_carry = e_q;

  // R1
  add_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && path_add_q) |-> (out_ovf == out_carry));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !path_add_q) |-> !out_ovf);

  // R5
  zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !path_add_q && out_mag == MAG_ZERO) |-> !out_sign);

  // R4
  fix_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FIX) |=> (out_sign != $past(out_sign)) && !out_carry);

  // R8
  out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      ($stable(out_mag) && $stable(out_sign) && $stable(out_ovf) && $stable(out_carry)));

endmodule

// File: tb/sim_sm_addsub.sv
module sim_sm_addsub;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready, in_sub, in_a_sign, in_b_sign;
  logic [W-1:0] in_a_mag, in_b_mag;
  logic         out_valid, out_ready, out_sign, out_ovf, out_carry;
  logic [W-1:0] out_mag;

  typedef struct {
    logic         sign;
    logic [W-1:0] mag;
    logic         ovf;
    logic         carry;
    int           lat;
    int           stall;
    string        req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  sm_addsub #(.MAG_W(W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_sub(in_sub),
    .in_a_sign(in_a_sign), .in_a_mag(in_a_mag),
    .in_b_sign(in_b_sign), .in_b_mag(in_b_mag),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sign(out_sign), .out_mag(out_mag),
    .out_ovf(out_ovf), .out_carry(out_carry)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic exp_t model(bit sub, bit as, int am, bit bs, int bm, int stall);
    exp_t e;
    int   s;
    e.stall = stall;
    if ((as == bs) != sub) begin
      s       = am + bm;
      e.mag   = s[W-1:0];
      e.carry = s[W];
      e.ovf   = s[W];
      e.sign  = as;
      e.lat   = 2;
      e.req   = "R1";
    end else if (am >= bm) begin
      e.mag   = W'(am - bm);
      e.carry = 1'b1;
      e.ovf   = 1'b0;
      e.sign  = (am == bm) ? 1'b0 : as;
      e.lat   = 2;
      e.req   = (am == bm) ? "R5" : "R3";
    end else begin
      e.mag   = W'(bm - am);
      e.carry = 1'b0;
      e.ovf   = 1'b0;
      e.sign  = ~as;
      e.lat   = 3;
      e.req   = "R4";
    end
    return e;
  endfunction

  // driver: pushes the expected item, offers the operation, measures latency
  task automatic run_op(bit sub, bit as, int am, bit bs, int bm, int stall, bit noise);
    exp_t e;
    int   n;
    e = model(sub, as, am, bs, bm, stall);
    q.push_back(e);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid  = 1'b1;
    in_sub    = sub;
    in_a_sign = as;
    in_a_mag  = W'(am);
    in_b_sign = bs;
    in_b_mag  = W'(bm);
    @(negedge clk);
    n = 1;
    if (noise) begin
      // R7: input offered while busy must be ignored
      check(in_ready == 1'b0, "R7", "in_ready while busy", int'(in_ready), 0);
      in_sub    = ~sub;
      in_a_sign = ~as;
      in_a_mag  = ~W'(am);
      in_b_mag  = ~W'(bm);
    end else begin
      in_valid = 1'b0;
    end
    while (!out_valid && n < 20) begin
      @(negedge clk);
      in_valid = 1'b0;
      n++;
    end
    // R6: result appears after the documented number of edges
    check(n == e.lat, "R6", "latency", n, e.lat);
  endtask

  // monitor: pops expected items and judges results and stalls
  initial begin
    exp_t         cur;
    bit           have = 0;
    int           stall = 0;
    logic [W-1:0] s_mag;
    logic         s_sign, s_ovf, s_carry;
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (out_ready) begin
        out_ready = 1'b0;
        have      = 0;
      end
      if (rst_n && out_valid) begin
        if (!have) begin
          if (q.size() == 0) begin
            check(1'b0, "R6", "unexpected result", 1, 0);
          end else begin
            cur = q.pop_front();
            check(out_mag   == cur.mag,   cur.req, "magnitude", int'(out_mag), int'(cur.mag));
            check(out_sign  == cur.sign,  cur.req, "sign",      int'(out_sign), int'(cur.sign));
            // R2: overflow flag only on the add path
            check(out_ovf   == cur.ovf,   cur.req, "overflow",  int'(out_ovf), int'(cur.ovf));
            check(out_carry == cur.carry, cur.req, "end carry", int'(out_carry), int'(cur.carry));
            stall = cur.stall;
          end
          have    = 1;
          s_mag   = out_mag;
          s_sign  = out_sign;
          s_ovf   = out_ovf;
          s_carry = out_carry;
        end else begin
          // R8: held result is frozen under back-pressure
          check(out_mag == s_mag && out_sign == s_sign && out_ovf == s_ovf && out_carry == s_carry,
                "R8", "held result changed", int'(out_mag), int'(s_mag));
          check(in_ready == 1'b0, "R8", "in_ready during hold", int'(in_ready), 0);
        end
        if (stall == 0) out_ready = 1'b1;
        else            stall--;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R6", "watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_sub    = 1'b0;
    in_a_sign = 1'b0;
    in_a_mag  = '0;
    in_b_sign = 1'b0;
    in_b_mag  = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(in_ready  == 1'b1, "R9", "in_ready",  int'(in_ready), 1);
    check(out_valid == 1'b0, "R9", "out_valid", int'(out_valid), 0);
    check(out_mag == '0 && out_sign == 1'b0 && out_ovf == 1'b0 && out_carry == 1'b0,
          "R9", "result outputs", int'(out_mag), 0);
    rst_n = 1'b1;

    run_op(0, 0,   5, 0,   3, 0, 0); // R1 plain add
    run_op(0, 1, 200, 1, 100, 0, 0); // R1 overflow, minus sign
    run_op(0, 0,  20, 1,  50, 0, 0); // R4 add with A<B
    run_op(0, 1,  50, 0,  20, 0, 0); // R3 add with A>B
    run_op(1, 0,   7, 0,  12, 0, 0); // R4 subtract, sign flips
    run_op(1, 0,  40, 1,  30, 0, 0); // R1 subtract of opposite signs
    run_op(1, 1,   9, 1,   9, 0, 0); // R5 minus zero suppressed
    run_op(0, 1,   9, 0,   9, 0, 0); // R5 via add path selection
    run_op(1, 0,   0, 0,   0, 0, 0); // R5 both zero
    run_op(0, 1,   0, 1,   0, 0, 0); // R1 add path keeps sign of A at zero
    run_op(1, 0, 255, 1,   1, 0, 0); // R1 wrap to zero with overflow
    run_op(1, 0,   0, 0, 255, 0, 0); // R4 widest difference
    run_op(0, 1, 255, 0,   0, 0, 0); // R3 B zero
    run_op(1, 1,  33, 0,  44, 3, 0); // R8 stalled result
    run_op(0, 0,  60, 1,  90, 2, 1); // R7 noise while busy, R8 stall
    run_op(1, 1, 128, 1,  17, 0, 1); // R7 noise on direct path

    for (int i = 0; i < 40; i++) begin
      run_op(1'($urandom), 1'($urandom), int'($urandom_range(0, 255)),
             1'($urandom), int'($urandom_range(0, 255)),
             int'($urandom_range(0, 2)), 1'($urandom));
    end

    for (int k = 0; k < 50 && (q.size() != 0 || !in_ready); k++) @(negedge clk);
    // R8: unit released back to idle, nothing outstanding
    check(q.size() == 0, "R8", "results outstanding", q.size(), 0);
    check(in_ready == 1'b1, "R8", "idle after drain", int'(in_ready), 1);
    done = 1;
    finish_run();
  end

endmodule